// File: doc/BRIEF.md
# Dual-Target Signed Vector Multiply-Accumulate Engine

This block takes two 128-bit operand vectors, multiplies them element by element as signed integers, and accumulates the products in one of two targets. The element size is 8 or 16 bits. In lane mode, every product is added into its own slot of a 512-bit lane accumulator. That accumulator is made of a low half and a high half of 256 bits each. In reduce mode, the products of all lanes are summed and the sum is added into a single 40-bit scalar accumulator. The lane accumulator can be cleared or preloaded from a 512-bit initial value. A clear also empties the scalar accumulator and its overflow flag.

Both accumulators are read out through a combinational shift-and-narrow path. Each slot, and the scalar total, is shifted arithmetically right by a programmable amount. The shifted value is then clamped to the signed range of the current element width. The lane results come out packed into a 128-bit word. The scalar result comes out as a 16-bit value. A sticky flag records any signed overflow of the scalar accumulator. The block sits beside a vector register file, which supplies the operands and takes the narrowed results.

Top module: `simd_mac_unit`

## Requirements
- R1: With `elem16`=0, operand byte i (bits 8i+7..8i, i = 0..15) of `op_a` and `op_b` is a signed 8-bit value. A lane-mode accumulate adds their product, sign-extended, to 32-bit slot i. Slot i sits at bits 32i+31..32i of the concatenation {`ld_hi`,`ld_lo`}: slots 0..7 fill the low half and slots 8..15 fill the high half. The narrowed slot i appears on `lane_q` bits 8i+7..8i.
- R2: With `elem16`=1, operand halfword j (bits 16j+15..16j, j = 0..7) is signed. A lane-mode accumulate adds the sign-extended product to 64-bit slot j, at bits 64j+63..64j of the same 512-bit layout. The narrowed slot j appears on `lane_q` bits 16j+15..16j.
- R3: With `ld`=1 and `clr`=0, the lane accumulator takes the value {`ld_hi`,`ld_lo`} at the next clock edge.
- R4: `clr`=1 sets the lane accumulator, the scalar accumulator and `red_ovf` to zero at the next edge. This holds whatever `ld` and `op_valid` show in the same cycle. Synchronous `rst` has the same effect.
- R5: Only one action takes effect per cycle, with clear first, then load, then accumulate. When `ld` and `op_valid` are both high, neither accumulator accumulates.
- R6: With `op_valid`=1 and `reduce_mode`=1, the sum of all lane products is added to the 40-bit scalar accumulator, which wraps modulo 2^40. There are 16 products for 8-bit elements and 8 products for 16-bit elements.
- R7: `red_ovf` becomes 1 when a reduce-mode add overflows the signed 40-bit range. It stays 1 until a clear or a reset.
- R8: Readout shifts each slot, and the scalar value, arithmetically right by `rd_shift` (0..63). The result is then saturated to [-128,127] when `elem16`=0 or to [-32768,32767] when `elem16`=1. The 8-bit scalar result is sign-extended onto `red_q`.
- R9: A lane-mode accumulate leaves the scalar accumulator and `red_ovf` unchanged. A reduce-mode accumulate leaves the lane accumulator unchanged. A cycle with no clear, load or accumulate changes neither accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Zero both accumulators and the overflow flag |
| ld | input | 1 | Preload the lane accumulator |
| op_valid | input | 1 | Accumulate this cycle's products |
| reduce_mode | input | 1 | 0 = lane target, 1 = scalar target |
| elem16 | input | 1 | 0 = 8-bit elements, 1 = 16-bit elements |
| op_a | input | 128 | First operand vector |
| op_b | input | 128 | Second operand vector |
| ld_hi | input | 256 | Preload value, upper half of the lane accumulator |
| ld_lo | input | 256 | Preload value, lower half of the lane accumulator |
| rd_shift | input | 6 | Arithmetic right-shift amount for readout |
| lane_q | output | 128 | Narrowed lane results |
| red_q | output | 16 | Narrowed scalar result |
| red_ovf | output | 1 | Sticky signed overflow of the scalar accumulator |

## Verification
The bench builds the block with its default parameters: 128-bit operands, 256-bit accumulator halves and a 40-bit scalar accumulator. The default sizes are what make the scalar overflow boundary reachable. Sixty-four 16-bit reductions of all-minimum operands carry the total exactly to 2^39, and that wraps the accumulator. Random shifts across the full 0..63 range reach both saturation limits and the exact-fit boundary for both element widths.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int DEF_VEC_W  = 128;
    localparam int DEF_HALF_W = 256;
    localparam int DEF_RED_W  = 40;
    localparam int SH_W       = 6;
    localparam int WIDE_W     = 64;

    typedef enum logic {ELEM_8 = 1'b0, ELEM_16 = 1'b1} elem_e;
    typedef enum logic {MODE_LANE = 1'b0, MODE_RED = 1'b1} mode_e;
    typedef enum logic [1:0] {ACT_HOLD, ACT_CLEAR, ACT_LOAD, ACT_ACCUM} act_e;

    typedef struct packed {
        act_e  act;
        mode_e mode;
        elem_e elem;
    } ctl_t;

    // One action per cycle: clear wins over load, load over accumulate.
    function automatic ctl_t decode_ctl(input logic clr, input logic ld,
                                        input logic op, input logic red,
                                        input logic e16);
        ctl_t c;
        if (clr)     c.act = ACT_CLEAR;
        else if (ld) c.act = ACT_LOAD;
        else if (op) c.act = ACT_ACCUM;
        else         c.act = ACT_HOLD;
        c.mode = red ? MODE_RED : MODE_LANE;
        c.elem = e16 ? ELEM_16 : ELEM_8;
        return c;
    endfunction

    // Arithmetic right shift followed by clamping to the element range.
    function automatic logic [15:0] sat_narrow(input logic signed [WIDE_W-1:0] v,
                                               input logic [SH_W-1:0] sh,
                                               input elem_e el);
        logic signed [WIDE_W-1:0] s;
        s = v >>> sh;
        if (el == ELEM_16) begin
            if (s > 64'sd32767)       return 16'h7fff;
            else if (s < -64'sd32768) return 16'h8000;
            else                      return s[15:0];
        end else begin
            if (s > 64'sd127)         return 16'h007f;
            else if (s < -64'sd128)   return 16'hff80;
            else                      return s[15:0];
        end
    endfunction

endpackage

// File: rtl/mac_products.sv
module mac_products #(
    parameter int VEC_W = mac_pkg::DEF_VEC_W
) (
    input  logic [VEC_W-1:0]   op_a,
    input  logic [VEC_W-1:0]   op_b,
    output logic [2*VEC_W-1:0] prod8,
    output logic [2*VEC_W-1:0] prod16
);
    localparam int N8  = VEC_W / 8;
    localparam int N16 = VEC_W / 16;

    for (genvar i = 0; i < N8; i++) begin : g_b
        logic signed [15:0] p;
        assign p = $signed(op_a[8*i +: 8]) * $signed(op_b[8*i +: 8]);
        assign prod8[16*i +: 16] = p;
    end

    for (genvar j = 0; j < N16; j++) begin : g_h
        logic signed [31:0] p;
        assign p = $signed(op_a[16*j +: 16]) * $signed(op_b[16*j +: 16]);
        assign prod16[32*j +: 32] = p;
    end
endmodule

// File: rtl/mac_lane_acc.sv
module mac_lane_acc
    import mac_pkg::*;
#(
    parameter int VEC_W = DEF_VEC_W,
    parameter int ACC_W = 2 * DEF_HALF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  ctl_t               ctl,
    input  logic [2*VEC_W-1:0] prod8,
    input  logic [2*VEC_W-1:0] prod16,
    input  logic [ACC_W-1:0]   ld_val,
    output logic [ACC_W-1:0]   acc_q
);
    localparam int N8   = VEC_W / 8;
    localparam int N16  = VEC_W / 16;
    localparam int SL8  = ACC_W / N8;
    localparam int SL16 = ACC_W / N16;

    logic [ACC_W-1:0] nxt;

    always_comb begin
        nxt = acc_q;
        unique case (ctl.act)
            ACT_CLEAR: nxt = '0;
            ACT_LOAD:  nxt = ld_val;
            ACT_ACCUM: begin
                if (ctl.mode == MODE_LANE) begin
                    if (ctl.elem == ELEM_8) begin
                        for (int i = 0; i < N8; i++)
                            nxt[SL8*i +: SL8] = acc_q[SL8*i +: SL8]
                                + SL8'($signed(prod8[16*i +: 16]));
                    end else begin
                        for (int j = 0; j < N16; j++)
                            nxt[SL16*j +: SL16] = acc_q[SL16*j +: SL16]
                                + SL16'($signed(prod16[32*j +: 32]));
                    end
                end
            end
            default: nxt = acc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= nxt;
    end
endmodule

// File: rtl/mac_reduce_acc.sv
module mac_reduce_acc
    import mac_pkg::*;
#(
    parameter int VEC_W = DEF_VEC_W,
    parameter int RED_W = DEF_RED_W
) (
    input  logic               clk,
    input  logic               rst,
    input  ctl_t               ctl,
    input  logic [2*VEC_W-1:0] prod8,
    input  logic [2*VEC_W-1:0] prod16,
    output logic [RED_W-1:0]   red_q,
    output logic               ovf_q
);
    localparam int N8  = VEC_W / 8;
    localparam int N16 = VEC_W / 16;
    localparam int MSB = RED_W - 1;

    logic [RED_W-1:0] sum, res;
    logic             ovf_now;

    always_comb begin
        sum = '0;
        if (ctl.elem == ELEM_16) begin
            for (int j = 0; j < N16; j++)
                sum = sum + RED_W'($signed(prod16[32*j +: 32]));
        end else begin
            for (int i = 0; i < N8; i++)
                sum = sum + RED_W'($signed(prod8[16*i +: 16]));
        end
        res     = red_q + sum;
        ovf_now = (red_q[MSB] == sum[MSB]) && (res[MSB] != red_q[MSB]);
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.act == ACT_CLEAR) begin
            red_q <= '0;
            ovf_q <= 1'b0;
        end else if (ctl.act == ACT_ACCUM && ctl.mode == MODE_RED) begin
            red_q <= res;
            ovf_q <= ovf_q | ovf_now;
        end
    end
endmodule

// File: rtl/mac_narrow.sv
module mac_narrow
    import mac_pkg::*;
#(
    parameter int VEC_W = DEF_VEC_W,
    parameter int ACC_W = 2 * DEF_HALF_W,
    parameter int RED_W = DEF_RED_W
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [RED_W-1:0] red,
    input  elem_e            elem,
    input  logic [SH_W-1:0]  sh,
    output logic [VEC_W-1:0] lane_q,
    output logic [15:0]      red_q
);
    localparam int N8   = VEC_W / 8;
    localparam int N16  = VEC_W / 16;
    localparam int SL8  = ACC_W / N8;
    localparam int SL16 = ACC_W / N16;

    logic [VEC_W-1:0] q8, q16;

    for (genvar i = 0; i < N8; i++) begin : g_n8
        logic [15:0] t;
        assign t = sat_narrow(WIDE_W'($signed(acc[SL8*i +: SL8])), sh, ELEM_8);
        assign q8[8*i +: 8] = t[7:0];
    end

    for (genvar j = 0; j < N16; j++) begin : g_n16
        assign q16[16*j +: 16] =
            sat_narrow(WIDE_W'($signed(acc[SL16*j +: SL16])), sh, ELEM_16);
    end

    assign lane_q = (elem == ELEM_16) ? q16 : q8;
    assign red_q  = sat_narrow(WIDE_W'($signed(red)), sh, elem);
endmodule

// File: rtl/simd_mac_unit.sv
module simd_mac_unit
    import mac_pkg::*;
#(
    parameter int VEC_W  = DEF_VEC_W,
    parameter int HALF_W = DEF_HALF_W,
    parameter int RED_W  = DEF_RED_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              ld,
    input  logic              op_valid,
    input  logic              reduce_mode,
    input  logic              elem16,
    input  logic [VEC_W-1:0]  op_a,
    input  logic [VEC_W-1:0]  op_b,
    input  logic [HALF_W-1:0] ld_hi,
    input  logic [HALF_W-1:0] ld_lo,
    input  logic [SH_W-1:0]   rd_shift,
    output logic [VEC_W-1:0]  lane_q,
    output logic [15:0]       red_q,
    output logic              red_ovf
);
    localparam int ACC_W = 2 * HALF_W;

    ctl_t               ctl;
    logic [2*VEC_W-1:0] prod8, prod16;
    logic [ACC_W-1:0]   lane_acc_q;
    logic [RED_W-1:0]   red_acc_q;

    assign ctl = decode_ctl(clr, ld, op_valid, reduce_mode, elem16);

    mac_products #(.VEC_W(VEC_W)) u_prod (
        .op_a(op_a), .op_b(op_b), .prod8(prod8), .prod16(prod16)
    );

    mac_lane_acc #(.VEC_W(VEC_W), .ACC_W(ACC_W)) u_lane (
        .clk(clk), .rst(rst), .ctl(ctl), .prod8(prod8), .prod16(prod16),
        .ld_val({ld_hi, ld_lo}), .acc_q(lane_acc_q)
    );

    mac_reduce_acc #(.VEC_W(VEC_W), .RED_W(RED_W)) u_red (
        .clk(clk), .rst(rst), .ctl(ctl), .prod8(prod8), .prod16(prod16),
        .red_q(red_acc_q), .ovf_q(red_ovf)
    );

    mac_narrow #(.VEC_W(VEC_W), .ACC_W(ACC_W), .RED_W(RED_W)) u_nar (
        .acc(lane_acc_q), .red(red_acc_q), .elem(ctl.elem), .sh(rd_shift),
        .lane_q(lane_q), .red_q(red_q)
    );
endmodule

// File: rtl/mac_checker.sv
module mac_checker #(
    parameter int ACC_W = 512,
    parameter int RED_W = 40
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             ld,
    input logic             op_valid,
    input logic             reduce_mode,
    input logic [ACC_W/2-1:0] ld_hi,
    input logic [ACC_W/2-1:0] ld_lo,
    input logic [ACC_W-1:0] lane_acc,
    input logic [RED_W-1:0] red_acc,
    input logic             red_ovf
);
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        clr |=> (lane_acc == '0) && (red_acc == '0) && !red_ovf);

    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        (ld && !clr) |=> lane_acc == $past({ld_hi, ld_lo}));

    p_load_first_r5: assert property (@(posedge clk) disable iff (rst)
        (ld && !clr && op_valid) |=> $stable(red_acc));

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (red_ovf && !clr) |=> red_ovf);

    p_lane_only_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !reduce_mode && !clr) |=> $stable(red_acc) && $stable(red_ovf));

    p_red_only_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && reduce_mode && !clr && !ld) |=> $stable(lane_acc));

    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!clr && !ld && !op_valid) |=> $stable(lane_acc) && $stable(red_acc));
endmodule

bind simd_mac_unit mac_checker #(.ACC_W(ACC_W), .RED_W(RED_W)) u_mac_chk (
    .clk(clk), .rst(rst), .clr(clr), .ld(ld), .op_valid(op_valid),
    .reduce_mode(reduce_mode), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .lane_acc(lane_acc_q), .red_acc(red_acc_q), .red_ovf(red_ovf)
);

// File: tb/test_simd_mac_unit.sv
module test_simd_mac_unit;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst, clr, ld, op_valid, reduce_mode, elem16;
    logic [127:0] op_a, op_b, lane_q;
    logic [255:0] ld_hi, ld_lo;
    logic [5:0]   rd_shift;
    logic [15:0]  red_q;
    logic         red_ovf;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [511:0] m_lane;
    logic [39:0]  m_red;
    bit           m_ovf;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_mac_unit i_simd_mac_unit (
        .clk(clk), .rst(rst), .clr(clr), .ld(ld), .op_valid(op_valid),
        .reduce_mode(reduce_mode), .elem16(elem16), .op_a(op_a), .op_b(op_b),
        .ld_hi(ld_hi), .ld_lo(ld_lo), .rd_shift(rd_shift),
        .lane_q(lane_q), .red_q(red_q), .red_ovf(red_ovf)
    );

    function automatic logic [15:0] exp_narrow(input longint v, input int sh, input bit wide);
        longint s, lo, hi;
        s  = v >>> sh;
        hi = wide ? 32767 : 127;
        lo = wide ? -32768 : -128;
        if (s > hi) s = hi;
        if (s < lo) s = lo;
        return s[15:0];
    endfunction

    function automatic logic [127:0] exp_lane(input bit wide, input int sh);
        logic [127:0] r;
        logic [15:0]  t;
        for (int k = 0; k < 16; k++) begin
            if (wide && k < 8) begin
                t = exp_narrow(longint'($signed(m_lane[64*k +: 64])), sh, 1'b1);
                r[16*k +: 16] = t;
            end else if (!wide) begin
                t = exp_narrow(longint'($signed(m_lane[32*k +: 32])), sh, 1'b0);
                r[8*k +: 8] = t[7:0];
            end
        end
        return r;
    endfunction

    task automatic check_all(input string tag);
        logic [127:0] el;
        logic [15:0]  er;
        el = exp_lane(elem16, int'(rd_shift));
        er = exp_narrow(longint'($signed(m_red)), int'(rd_shift), elem16);
        total++;
        if (lane_q !== el) begin
            bad++;
            $display("FAIL %s lane_q actual=%h expected=%h", tag, lane_q, el);
        end
        total++;
        if (red_q !== er) begin
            bad++;
            $display("FAIL %s red_q actual=%h expected=%h", tag, red_q, er);
        end
        total++;
        if (red_ovf !== m_ovf) begin
            bad++;
            $display("FAIL %s red_ovf actual=%b expected=%b", tag, red_ovf, m_ovf);
        end
    endtask

    task automatic model_step(input bit c, input bit l, input bit o, input bit m,
                              input bit e, input logic [127:0] a,
                              input logic [127:0] b, input logic [511:0] lv);
        longint p, sum, full;
        if (c) begin
            m_lane = '0; m_red = '0; m_ovf = 0;
        end else if (l) begin
            m_lane = lv;
        end else if (o && !m) begin
            if (e) begin
                for (int j = 0; j < 8; j++) begin
                    p = longint'($signed(a[16*j +: 16])) * longint'($signed(b[16*j +: 16]));
                    m_lane[64*j +: 64] = m_lane[64*j +: 64] + p;
                end
            end else begin
                for (int i = 0; i < 16; i++) begin
                    p = longint'($signed(a[8*i +: 8])) * longint'($signed(b[8*i +: 8]));
                    m_lane[32*i +: 32] = m_lane[32*i +: 32] + p[31:0];
                end
            end
        end else if (o && m) begin
            sum = 0;
            for (int k = 0; k < (e ? 8 : 16); k++) begin
                if (e) sum += longint'($signed(a[16*k +: 16])) * longint'($signed(b[16*k +: 16]));
                else   sum += longint'($signed(a[8*k +: 8]))   * longint'($signed(b[8*k +: 8]));
            end
            full = longint'($signed(m_red)) + sum;
            if (full > 64'sh7F_FFFF_FFFF || full < -64'sh80_0000_0000) m_ovf = 1;
            m_red = full[39:0];
        end
    endtask

    task automatic cyc(input string tag, input bit c, input bit l, input bit o,
                       input bit m, input bit e, input logic [127:0] a,
                       input logic [127:0] b, input logic [511:0] lv,
                       input logic [5:0] sh);
        @(negedge clk);
        clr = c; ld = l; op_valid = o; reduce_mode = m; elem16 = e;
        op_a = a; op_b = b; ld_hi = lv[511:256]; ld_lo = lv[255:0]; rd_shift = sh;
        model_step(c, l, o, m, e, a, b, lv);
        @(posedge clk);
        #1;
        check_all(tag);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    function automatic logic [511:0] rnd512();
        logic [511:0] r;
        for (int k = 0; k < 16; k++) r[32*k +: 32] = $urandom();
        return r;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] va, vb;
        logic [511:0] lv;
        void'($urandom(32'd1234));
        rst = 1; clr = 0; ld = 0; op_valid = 0; reduce_mode = 0; elem16 = 0;
        op_a = '0; op_b = '0; ld_hi = '0; ld_lo = '0; rd_shift = '0;
        m_lane = '0; m_red = '0; m_ovf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check_all("R4 reset");

        // R1: byte lanes, small known values, then random
        va = {16{8'hfd}}; vb = {8{8'h05, 8'h80}};
        cyc("R1 bytes", 0, 0, 1, 0, 0, va, vb, '0, 6'd0);
        cyc("R1 bytes shift", 0, 0, 1, 0, 0, rnd128(), rnd128(), '0, 6'd7);
        // R2: halfword lanes
        cyc("R2 halves", 0, 1, 0, 0, 1, '0, '0, '0, 6'd0);
        cyc("R2 halves", 0, 0, 1, 0, 1, {8{16'h8000}}, {8{16'h7fff}}, '0, 6'd16);
        cyc("R2 halves", 0, 0, 1, 0, 1, rnd128(), rnd128(), '0, 6'd3);
        // R3 load, R8 saturation boundaries
        lv = {8{64'h0000_0000_7fff_ffff}};
        cyc("R3 load", 0, 1, 0, 0, 0, '0, '0, lv, 6'd24);
        cyc("R8 exact fit", 0, 0, 0, 0, 0, '0, '0, '0, 6'd24);
        cyc("R8 sat high", 0, 0, 0, 0, 0, '0, '0, '0, 6'd23);
        cyc("R8 sat wide", 0, 0, 0, 0, 1, '0, '0, '0, 6'd0);
        lv = {16{32'h8000_0000}};
        cyc("R8 sat low", 0, 1, 0, 0, 0, '0, '0, lv, 6'd0);
        cyc("R8 neg shift", 0, 0, 0, 0, 0, '0, '0, '0, 6'd24);
        // R5 load beats accumulate, R4 clear beats both
        cyc("R5 load first", 0, 1, 1, 1, 1, {8{16'h8000}}, {8{16'h8000}}, rnd512(), 6'd5);
        cyc("R5 load first", 0, 1, 1, 0, 0, rnd128(), rnd128(), rnd512(), 6'd9);
        cyc("R4 clear first", 1, 1, 1, 0, 0, rnd128(), rnd128(), rnd512(), 6'd0);
        // R6/R7: 64 reductions of 8*2^30 reach 2^39 and wrap
        for (int n = 0; n < 64; n++)
            cyc("R6 R7 wrap", 0, 0, 1, 1, 1, {8{16'h8000}}, {8{16'h8000}}, '0, 6'd24);
        cyc("R7 sticky", 0, 0, 1, 1, 0, rnd128(), rnd128(), '0, 6'd24);
        cyc("R9 lane op keeps scalar", 0, 0, 1, 0, 0, rnd128(), rnd128(), '0, 6'd24);
        cyc("R9 idle", 0, 0, 0, 1, 1, rnd128(), rnd128(), rnd512(), 6'd30);
        cyc("R4 clear flag", 1, 0, 0, 0, 0, '0, '0, '0, 6'd0);

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            bit c, l;
            c = ($urandom() % 40) == 0;
            l = ($urandom() % 12) == 0;
            cyc("R9 random", c, l, ($urandom() % 4) != 0, $urandom() % 2,
                $urandom() % 2, rnd128(), rnd128(), rnd512(), 6'($urandom() % 64));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule